// File: doc/BRIEF.md
# Boot-Overlay Memory Bus Decoder

This block sits between an 8-bit processor and the memories and peripherals of a 16-bit address space. Each cycle it looks at the request address and the read and write strobes, raises exactly one chip-select, and hands the target a local index built from the low address bits, together with the shared write data and write enable. Read data from the selected target is captured into a register, so the processor sees it one clock after its read strobe, with a valid flag.

A single overlay flag, set by reset, places a 256-byte boot image over the bottom of the cartridge ROM for reads. The flag drops once the boot code fetches its final byte, or when software writes the overlay-release I/O address. After that only another reset brings it back. Beside the data path the block produces three one-cycle side pulses: a tile-update strobe for writes into the tile half of video RAM, an error flag for forbidden ROM writes, and a flag for touches of I/O addresses with nothing behind them.

The external memories and the video and input peripherals are not part of the block. They answer combinationally on their own select lines.

Top module: `membus_router`

## Requirements
- R1: After synchronous reset `boot_overlay` is 1, `cpu_rvalid` is 0 and `tile_stb`, `rom_wr_err` and `bus_unmapped` are 0.
- R2: While `boot_overlay` is 1, a read of 0x0000..0x00FE selects `boot_cs`, with `boot_addr` equal to the low 8 address bits, and returns the boot byte. A read of 0x00FF still returns ROM.
- R3: A read of 0x00FE while the overlay is active returns the boot byte and then clears `boot_overlay`. A write of any value to 0xFF50 also clears it. Once cleared it stays 0 until reset, and 0x0000..0x00FE then read ROM.
- R4: Reads of 0x0000..0x7FFF select `rom_cs` with `rom_addr` = address bits 14:0. A write to 0x2000 has no effect and raises no flag. Any other write below 0x8000 pulses `rom_wr_err` for one cycle, starting the cycle after the write.
- R5: 0x8000..0x9FFF selects video RAM, 0xA000..0xBFFF selects external RAM and 0xC000..0xDFFF selects work RAM, each indexed by address bits 12:0, for both reads and writes.
- R6: 0xE000..0xFDFF reaches work RAM through the same 13-bit index, for both reads and writes.
- R7: Reads of 0xFE00..0xFEFF return 0x00. Writes there assert no chip-select and raise no flag.
- R8: 0xFF80..0xFFFF selects the 128-byte high RAM, indexed by address bits 6:0.
- R9: Reads of 0xFF40..0xFF7F and writes of 0xFF40..0xFF4F or 0xFF60..0xFF7F select the video register port, with `vreg_addr` = the low 8 address bits. Writes of 0xFF00..0xFF0F select the input/timer port, with `pad_addr` = the low 4 bits.
- R10: A write to 0x8000..0x97FF pulses `tile_stb` for one cycle, in the cycle after the write, with `tile_addr` = address bits 12:0 and `tile_data` = the written byte. Writes at 0x9800 and above do not pulse it.
- R11: Reads of 0xFF00..0xFF3F, and writes of 0xFF10..0xFF3F or 0xFF51..0xFF5F, return 0xFF on reads and pulse `bus_unmapped` for one cycle after the access. They leave `boot_overlay` unchanged.
- R12: `cpu_rdata` and `cpu_rvalid` are valid in the cycle after `cpu_rd`. Selects are combinational and at most one is high. When `cpu_rd` and `cpu_wr` are both high the access is a read, and `mem_we` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | Request address |
| cpu_wdata | input | 8 | Write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_rdata | output | 8 | Registered read data |
| cpu_rvalid | output | 1 | Read data valid, one cycle after cpu_rd |
| mem_wdata | output | 8 | Write data to all targets |
| mem_we | output | 1 | Write enable, qualified by a select |
| boot_cs | output | 1 | Boot image select |
| boot_addr | output | 8 | Boot image index |
| boot_rdata | input | 8 | Boot image data |
| rom_cs | output | 1 | Cartridge ROM select (reads) |
| rom_addr | output | 15 | ROM index |
| rom_rdata | input | 8 | ROM data |
| vram_cs | output | 1 | Video RAM select |
| vram_addr | output | 13 | Video RAM index |
| vram_rdata | input | 8 | Video RAM data |
| eram_cs | output | 1 | External RAM select |
| eram_addr | output | 13 | External RAM index |
| eram_rdata | input | 8 | External RAM data |
| wram_cs | output | 1 | Work RAM select (direct and mirror) |
| wram_addr | output | 13 | Work RAM index |
| wram_rdata | input | 8 | Work RAM data |
| hram_cs | output | 1 | High RAM select |
| hram_addr | output | 7 | High RAM index |
| hram_rdata | input | 8 | High RAM data |
| vreg_cs | output | 1 | Video register port select |
| vreg_addr | output | 8 | Video register index |
| vreg_rdata | input | 8 | Video register data |
| pad_cs | output | 1 | Input/timer port select (writes) |
| pad_addr | output | 4 | Input/timer register index |
| tile_stb | output | 1 | Tile-update pulse |
| tile_addr | output | 13 | Tile-update video RAM index |
| tile_data | output | 8 | Tile-update byte |
| rom_wr_err | output | 1 | Forbidden ROM write pulse |
| bus_unmapped | output | 1 | Unmapped I/O access pulse |
| boot_overlay | output | 1 | Boot overlay active |

## Verification
The bench aims at the edges of the overlay window. If 0x00FF were also taken from the boot image, or if the 0x00FE fetch left the flag set, later reads of low ROM would return boot bytes. The release write at 0xFF50 is exercised after a second reset, and its neighbour 0xFF51 is checked to leave the flag alone. A decoder with an off-by-one at 0x9800 would drop tile strobes or raise stray ones. A wrong mirror index would break the round-trips between 0xC123/0xE123 and 0xFDFF/0xDDFF. Treating 0x2000 as a bad write would raise a false error. A write that overrode a read on a collision would corrupt work RAM.

// File: rtl/mbr_pkg.sv
// Shared widths, address-map constants and the region type of the bus decoder.
// Assumes a 16-bit address space and 8-bit data.
package mbr_pkg;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int BOOT_AW = 8;
    localparam int ROM_AW  = 15;
    localparam int BANK_AW = 13;
    localparam int HRAM_AW = 7;
    localparam int VREG_AW = 8;
    localparam int PAD_AW  = 4;

    localparam logic [ADDR_W-1:0] BOOT_LAST      = 16'h00FE;
    localparam logic [ADDR_W-1:0] ROM_WR_IGNORE  = 16'h2000;
    localparam logic [ADDR_W-1:0] VRAM_BASE      = 16'h8000;
    localparam logic [ADDR_W-1:0] ERAM_BASE      = 16'hA000;
    localparam logic [ADDR_W-1:0] WRAM_BASE      = 16'hC000;
    localparam logic [ADDR_W-1:0] OAM_BASE       = 16'hFE00;
    localparam logic [ADDR_W-1:0] IO_BASE        = 16'hFF00;
    localparam logic [ADDR_W-1:0] HRAM_BASE      = 16'hFF80;
    localparam logic [ADDR_W-1:0] TILE_LIMIT     = 16'h9800;
    localparam logic [ADDR_W-1:0] OVL_RELEASE    = 16'hFF50;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_BOOT,
        RG_ROM,
        RG_ROM_WR_OK,
        RG_ROM_WR_BAD,
        RG_VRAM,
        RG_ERAM,
        RG_WRAM,
        RG_OAM,
        RG_VREG,
        RG_PAD,
        RG_HRAM,
        RG_OVL_OFF,
        RG_UNMAP
    } region_e;
endpackage

// File: rtl/mbr_addr_decode.sv
// Address decoder: classifies the current request into one region.
// Purely combinational. A read wins over a write when both strobes are high.
// The boot window applies to reads only, and only while the overlay flag is set.
module mbr_addr_decode
    import mbr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              overlay,
    output region_e           region
);
    localparam logic [3:0] IO_HI_VID_A = 4'h4;
    localparam logic [3:0] IO_HI_OVL   = 4'h5;
    localparam logic [3:0] IO_HI_VID_B = 4'h6;
    localparam logic [3:0] IO_HI_VID_C = 4'h7;
    localparam logic [3:0] IO_HI_PAD   = 4'h0;

    logic [3:0] io_hi;
    assign io_hi = addr[7:4];

    // Map the request to its region, reads first, then writes.
    always_comb begin
        region = RG_NONE;
        if (rd) begin
            if (overlay && addr <= BOOT_LAST)       region = RG_BOOT;
            else if (addr < VRAM_BASE)              region = RG_ROM;
            else if (addr < ERAM_BASE)              region = RG_VRAM;
            else if (addr < WRAM_BASE)              region = RG_ERAM;
            else if (addr < OAM_BASE)               region = RG_WRAM;
            else if (addr < IO_BASE)                region = RG_OAM;
            else if (addr >= HRAM_BASE)             region = RG_HRAM;
            else if (io_hi >= IO_HI_VID_A)          region = RG_VREG;
            else                                    region = RG_UNMAP;
        end else if (wr) begin
            if (addr < VRAM_BASE)
                region = (addr == ROM_WR_IGNORE) ? RG_ROM_WR_OK : RG_ROM_WR_BAD;
            else if (addr < ERAM_BASE)              region = RG_VRAM;
            else if (addr < WRAM_BASE)              region = RG_ERAM;
            else if (addr < OAM_BASE)               region = RG_WRAM;
            else if (addr < IO_BASE)                region = RG_OAM;
            else if (addr >= HRAM_BASE)             region = RG_HRAM;
            else begin
                case (io_hi)
                    IO_HI_PAD:   region = RG_PAD;
                    IO_HI_VID_A,
                    IO_HI_VID_B,
                    IO_HI_VID_C: region = RG_VREG;
                    IO_HI_OVL:   region = (addr == OVL_RELEASE) ? RG_OVL_OFF : RG_UNMAP;
                    default:     region = RG_UNMAP;
                endcase
            end
        end
    end

    // R12: no region without a strobe
    always_comb begin
        if (!rd && !wr) begin
            p_idle_none_r12: assert (region == RG_NONE);
        end
    end
endmodule

// File: rtl/mbr_boot_overlay.sv
// Boot overlay flag: one flip-flop, set by synchronous reset, only cleared later.
// Assumes the clear requests are single-cycle qualified accesses.
module mbr_boot_overlay (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_fetch,
    input  logic clr_write,
    output logic active
);
    // Hold the flag; either clear source drops it for good.
    always_ff @(posedge clk) begin
        if (!rst_n)                      active <= 1'b1;
        else if (clr_fetch || clr_write) active <= 1'b0;
    end

    // R3: once released the overlay never comes back without reset
    p_overlay_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !active);
endmodule

// File: rtl/mbr_read_return.sv
// Read return path: picks the target data by region and registers it.
// Assumes targets answer combinationally within the strobe cycle.
module mbr_read_return
    import mbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  region_e           region,
    input  logic [DATA_W-1:0] boot_rdata,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [DATA_W-1:0] vram_rdata,
    input  logic [DATA_W-1:0] eram_rdata,
    input  logic [DATA_W-1:0] wram_rdata,
    input  logic [DATA_W-1:0] hram_rdata,
    input  logic [DATA_W-1:0] vreg_rdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam logic [DATA_W-1:0] OAM_VALUE   = '0;
    localparam logic [DATA_W-1:0] FLOAT_VALUE = '1;

    logic [DATA_W-1:0] sel;

    // Choose the byte belonging to the selected region.
    always_comb begin
        case (region)
            RG_BOOT: sel = boot_rdata;
            RG_ROM:  sel = rom_rdata;
            RG_VRAM: sel = vram_rdata;
            RG_ERAM: sel = eram_rdata;
            RG_WRAM: sel = wram_rdata;
            RG_HRAM: sel = hram_rdata;
            RG_VREG: sel = vreg_rdata;
            RG_OAM:  sel = OAM_VALUE;
            default: sel = FLOAT_VALUE;
        endcase
    end

    // Capture the byte and the valid flag one clock after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd;
            if (rd) rdata <= sel;
        end
    end

    // R12: every read strobe yields valid data on the next cycle
    p_rvalid_next_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid);
    // R11: unmapped reads float high
    p_unmapped_ff_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && region == RG_UNMAP) |=> rdata == FLOAT_VALUE);
    // R7: sprite attribute reads are zero
    p_oam_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && region == RG_OAM) |=> rdata == OAM_VALUE);
endmodule

// File: rtl/mbr_side_events.sv
// Side pulses: tile update, forbidden ROM write and unmapped access.
// All registered, one cycle wide, following the access that caused them.
module mbr_side_events
    import mbr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  region_e            region,
    input  logic               is_wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic               tile_stb,
    output logic [BANK_AW-1:0] tile_addr,
    output logic [DATA_W-1:0]  tile_data,
    output logic               rom_wr_err,
    output logic               unmapped
);
    localparam logic [BANK_AW-1:0] TILE_IDX_LIMIT = TILE_LIMIT[BANK_AW-1:0];

    logic tile_hit;
    assign tile_hit = is_wr && (region == RG_VRAM) && (addr < TILE_LIMIT);

    // Register the pulses and the tile payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tile_stb   <= 1'b0;
            tile_addr  <= '0;
            tile_data  <= '0;
            rom_wr_err <= 1'b0;
            unmapped   <= 1'b0;
        end else begin
            tile_stb   <= tile_hit;
            rom_wr_err <= (region == RG_ROM_WR_BAD);
            unmapped   <= (region == RG_UNMAP);
            if (tile_hit) begin
                tile_addr <= addr[BANK_AW-1:0];
                tile_data <= wdata;
            end
        end
    end

    // R10: a tile strobe always points into the tile half of video RAM
    p_tile_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tile_stb |-> tile_addr < TILE_IDX_LIMIT);
    // R10: pulses last exactly one cycle for an isolated write
    p_tile_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tile_stb && !tile_hit) |=> !tile_stb);
endmodule

// File: rtl/membus_router.sv
// Top of the boot-overlay bus decoder. Decodes each request, drives one select
// with a local index, registers read data, keeps the overlay flag and the side pulses.
// Assumes single-cycle accesses and combinational target read data.
module membus_router
    import mbr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               cpu_rvalid,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               mem_we,
    output logic               boot_cs,
    output logic [BOOT_AW-1:0] boot_addr,
    input  logic [DATA_W-1:0]  boot_rdata,
    output logic               rom_cs,
    output logic [ROM_AW-1:0]  rom_addr,
    input  logic [DATA_W-1:0]  rom_rdata,
    output logic               vram_cs,
    output logic [BANK_AW-1:0] vram_addr,
    input  logic [DATA_W-1:0]  vram_rdata,
    output logic               eram_cs,
    output logic [BANK_AW-1:0] eram_addr,
    input  logic [DATA_W-1:0]  eram_rdata,
    output logic               wram_cs,
    output logic [BANK_AW-1:0] wram_addr,
    input  logic [DATA_W-1:0]  wram_rdata,
    output logic               hram_cs,
    output logic [HRAM_AW-1:0] hram_addr,
    input  logic [DATA_W-1:0]  hram_rdata,
    output logic               vreg_cs,
    output logic [VREG_AW-1:0] vreg_addr,
    input  logic [DATA_W-1:0]  vreg_rdata,
    output logic               pad_cs,
    output logic [PAD_AW-1:0]  pad_addr,
    output logic               tile_stb,
    output logic [BANK_AW-1:0] tile_addr,
    output logic [DATA_W-1:0]  tile_data,
    output logic               rom_wr_err,
    output logic               bus_unmapped,
    output logic               boot_overlay
);
    region_e region;
    logic    is_wr;

    assign is_wr = cpu_wr && !cpu_rd;

    mbr_addr_decode u_decode (
        .addr    (cpu_addr),
        .rd      (cpu_rd),
        .wr      (cpu_wr),
        .overlay (boot_overlay),
        .region  (region)
    );

    mbr_boot_overlay u_overlay (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_fetch (region == RG_BOOT && cpu_addr == BOOT_LAST),
        .clr_write (region == RG_OVL_OFF),
        .active    (boot_overlay)
    );

    mbr_read_return u_rdret (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd         (cpu_rd),
        .region     (region),
        .boot_rdata (boot_rdata),
        .rom_rdata  (rom_rdata),
        .vram_rdata (vram_rdata),
        .eram_rdata (eram_rdata),
        .wram_rdata (wram_rdata),
        .hram_rdata (hram_rdata),
        .vreg_rdata (vreg_rdata),
        .rdata      (cpu_rdata),
        .rvalid     (cpu_rvalid)
    );

    mbr_side_events u_events (
        .clk        (clk),
        .rst_n      (rst_n),
        .region     (region),
        .is_wr      (is_wr),
        .addr       (cpu_addr),
        .wdata      (cpu_wdata),
        .tile_stb   (tile_stb),
        .tile_addr  (tile_addr),
        .tile_data  (tile_data),
        .rom_wr_err (rom_wr_err),
        .unmapped   (bus_unmapped)
    );

    // Drive the selects and local indices of every target.
    always_comb begin
        boot_cs   = (region == RG_BOOT);
        rom_cs    = (region == RG_ROM);
        vram_cs   = (region == RG_VRAM);
        eram_cs   = (region == RG_ERAM);
        wram_cs   = (region == RG_WRAM);
        hram_cs   = (region == RG_HRAM);
        vreg_cs   = (region == RG_VREG);
        pad_cs    = (region == RG_PAD);
        boot_addr = cpu_addr[BOOT_AW-1:0];
        rom_addr  = cpu_addr[ROM_AW-1:0];
        vram_addr = cpu_addr[BANK_AW-1:0];
        eram_addr = cpu_addr[BANK_AW-1:0];
        wram_addr = cpu_addr[BANK_AW-1:0];
        hram_addr = cpu_addr[HRAM_AW-1:0];
        vreg_addr = cpu_addr[VREG_AW-1:0];
        pad_addr  = cpu_addr[PAD_AW-1:0];
        mem_wdata = cpu_wdata;
        mem_we    = is_wr;
    end

    // R3: the last boot fetch releases the overlay
    p_release_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_overlay && cpu_rd && cpu_addr == 16'h00FE) |=> !boot_overlay);
    // R3: the release write drops the overlay
    p_release_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_rd && cpu_addr == 16'hFF50) |=> !boot_overlay);
    // R4: a ROM write other than 0x2000 flags an error next cycle
    p_rom_write_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_rd && !cpu_addr[15] && cpu_addr != 16'h2000) |=> rom_wr_err);
    // R10: a write into the tile area raises the tile strobe next cycle
    p_tile_raise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_rd && cpu_addr >= 16'h8000 && cpu_addr < 16'h9800) |=> tile_stb);
    // R11: unmapped reads in the low I/O page raise the flag next cycle
    p_unmapped_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr >= 16'hFF00 && cpu_addr < 16'hFF40) |=> bus_unmapped);
    // R12: at most one select at a time
    p_one_select_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({boot_cs, rom_cs, vram_cs, eram_cs, wram_cs, hram_cs, vreg_cs, pad_cs}));
endmodule

// File: tb/membus_router_test.sv
// Scoreboard bench for membus_router: read tasks queue expected bytes,
// a monitor pops them as cpu_rvalid appears. Targets are small behavioural models.
module membus_router_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        cpu_rvalid;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        boot_cs, rom_cs, vram_cs, eram_cs, wram_cs, hram_cs, vreg_cs, pad_cs;
    logic [7:0]  boot_addr, vreg_addr;
    logic [14:0] rom_addr;
    logic [12:0] vram_addr, eram_addr, wram_addr, tile_addr;
    logic [6:0]  hram_addr;
    logic [3:0]  pad_addr;
    logic [7:0]  boot_rdata, rom_rdata, vram_rdata, eram_rdata, wram_rdata, hram_rdata, vreg_rdata;
    logic        tile_stb, rom_wr_err, bus_unmapped, boot_overlay;
    logic [7:0]  tile_data;

    int n_vec = 0;
    int n_bad = 0;
    int wr_count = 0;
    logic [3:0] pad_last_addr = '0;
    logic [7:0] pad_last_data = '0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;
    rd_item_t sb[$];

    logic [7:0] vram_m [256];
    logic [7:0] eram_m [256];
    logic [7:0] wram_m [256];
    logic [7:0] hram_m [128];
    logic [7:0] vreg_m [256];

    always #10 clk = ~clk;

    membus_router uut (.*);

    function automatic logic [7:0] boot_byte(input logic [7:0] a);
        return a + 8'h80;
    endfunction
    function automatic logic [7:0] rom_byte(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h3C;
    endfunction

    assign boot_rdata = boot_byte(boot_addr);
    assign rom_rdata  = rom_byte(rom_addr);
    assign vram_rdata = vram_m[vram_addr[7:0]];
    assign eram_rdata = eram_m[eram_addr[7:0]];
    assign wram_rdata = wram_m[wram_addr[7:0]];
    assign hram_rdata = hram_m[hram_addr];
    assign vreg_rdata = vreg_m[vreg_addr];

    initial begin
        for (int i = 0; i < 256; i++) begin
            vram_m[i] = 8'h00;
            eram_m[i] = 8'h00;
            wram_m[i] = 8'h00;
            vreg_m[i] = 8'(i) ^ 8'hA5;
        end
        for (int i = 0; i < 128; i++) hram_m[i] = 8'h00;
    end

    // Target models absorb writes on their selects.
    always @(posedge clk) begin
        if (mem_we) begin
            if (vram_cs) vram_m[vram_addr[7:0]] <= mem_wdata;
            if (eram_cs) eram_m[eram_addr[7:0]] <= mem_wdata;
            if (wram_cs) wram_m[wram_addr[7:0]] <= mem_wdata;
            if (hram_cs) hram_m[hram_addr] <= mem_wdata;
            if (vreg_cs) vreg_m[vreg_addr] <= mem_wdata;
            if (pad_cs) begin
                pad_last_addr <= pad_addr;
                pad_last_data <= mem_wdata;
            end
            if (vram_cs || eram_cs || wram_cs || hram_cs || vreg_cs || pad_cs)
                wr_count <= wr_count + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare each returned byte against the queued expectation.
    always @(negedge clk) begin
        if (rst_n && cpu_rvalid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R12 unexpected rvalid", {8'h0, cpu_rdata}, 16'h0);
            end else begin
                rd_item_t it;
                it = sb.pop_front();
                check(cpu_rdata == it.exp, it.tag, {8'h0, cpu_rdata}, {8'h0, it.exp});
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        cpu_rd = 1'b0;
        cpu_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
        rd_item_t it;
        @(negedge clk);
        cpu_addr = a;
        cpu_rd = 1'b1;
        cpu_wr = 1'b0;
        it.exp = exp;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        cpu_wdata = d;
        cpu_rd = 1'b0;
        cpu_wr = 1'b1;
        idle();
    endtask

    task automatic pulse_chk(input string tag, input bit e_rom, input bit e_unm, input bit e_tile);
        check(rom_wr_err == e_rom, {tag, " rom_wr_err"}, {15'h0, rom_wr_err}, {15'h0, e_rom});
        check(bus_unmapped == e_unm, {tag, " bus_unmapped"}, {15'h0, bus_unmapped}, {15'h0, e_unm});
        check(tile_stb == e_tile, {tag, " tile_stb"}, {15'h0, tile_stb}, {15'h0, e_tile});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cpu_rd = 1'b0;
        cpu_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        #(20 * 100000);
        check(1'b0, "watchdog expired", 16'h0, 16'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : driver
        int wc;
        do_reset();
        // R1 reset state
        check(boot_overlay == 1'b1, "R1 overlay", {15'h0, boot_overlay}, 16'h1);
        check(cpu_rvalid == 1'b0, "R1 rvalid", {15'h0, cpu_rvalid}, 16'h0);
        pulse_chk("R1", 1'b0, 1'b0, 1'b0);

        // R2 boot window reads
        do_rd(16'h0000, boot_byte(8'h00), "R2 boot 0000");
        do_rd(16'h0042, boot_byte(8'h42), "R2 boot 0042");
        do_rd(16'h00FF, rom_byte(15'h00FF), "R2 rom 00FF");
        idle();
        check(cpu_rvalid == 1'b1, "R12 rvalid after read", {15'h0, cpu_rvalid}, 16'h1);
        idle();
        check(cpu_rvalid == 1'b0, "R12 rvalid drops", {15'h0, cpu_rvalid}, 16'h0);
        check(boot_overlay == 1'b1, "R2 overlay kept", {15'h0, boot_overlay}, 16'h1);

        // R11 unmapped I/O
        do_wr(16'hFF51, 8'h01);
        pulse_chk("R11 wr FF51", 1'b0, 1'b1, 1'b0);
        check(boot_overlay == 1'b1, "R11 FF51 keeps overlay", {15'h0, boot_overlay}, 16'h1);
        do_wr(16'hFF20, 8'h02);
        pulse_chk("R11 wr FF20", 1'b0, 1'b1, 1'b0);
        do_rd(16'hFF10, 8'hFF, "R11 rd FF10");
        idle();
        check(bus_unmapped == 1'b1, "R11 rd FF10 flag", {15'h0, bus_unmapped}, 16'h1);

        // R4 ROM writes
        do_wr(16'h2000, 8'h05);
        pulse_chk("R4 wr 2000", 1'b0, 1'b0, 1'b0);
        do_wr(16'h1234, 8'h05);
        pulse_chk("R4 wr 1234", 1'b1, 1'b0, 1'b0);
        idle();
        check(rom_wr_err == 1'b0, "R4 err one cycle", {15'h0, rom_wr_err}, 16'h0);
        do_wr(16'h0010, 8'h05);
        pulse_chk("R4 wr 0010 in overlay", 1'b1, 1'b0, 1'b0);
        do_rd(16'h7ABC, rom_byte(15'h7ABC), "R4 rom 7ABC");

        // R10 tile strobe and R5 video RAM
        do_wr(16'h8010, 8'hAB);
        pulse_chk("R10 wr 8010", 1'b0, 1'b0, 1'b1);
        check(tile_addr == 13'h0010, "R10 tile_addr", {3'h0, tile_addr}, 16'h0010);
        check(tile_data == 8'hAB, "R10 tile_data", {8'h0, tile_data}, 16'h00AB);
        do_wr(16'h9800, 8'hCD);
        pulse_chk("R10 wr 9800", 1'b0, 1'b0, 1'b0);
        do_wr(16'h97FF, 8'hEF);
        pulse_chk("R10 wr 97FF", 1'b0, 1'b0, 1'b1);
        check(tile_addr == 13'h17FF, "R10 tile_addr 17FF", {3'h0, tile_addr}, 16'h17FF);
        do_rd(16'h8010, 8'hAB, "R5 vram 8010");
        do_rd(16'h9800, 8'hCD, "R5 vram 9800");

        // R5 external and work RAM
        do_wr(16'hA133, 8'h5C);
        do_rd(16'hA133, 8'h5C, "R5 eram A133");
        do_wr(16'hC123, 8'h11);
        do_rd(16'hC123, 8'h11, "R5 wram C123");

        // R6 mirror both ways
        do_rd(16'hE123, 8'h11, "R6 mirror read E123");
        do_wr(16'hFDFF, 8'h22);
        do_rd(16'hDDFF, 8'h22, "R6 mirror write FDFF");

        // R7 sprite attribute space
        idle();
        wc = wr_count;
        do_wr(16'hFE10, 8'h77);
        pulse_chk("R7 wr FE10", 1'b0, 1'b0, 1'b0);
        idle();
        check(wr_count == wc, "R7 no write reached", wr_count[15:0], wc[15:0]);
        do_rd(16'hFE10, 8'h00, "R7 oam read");

        // R8 high RAM
        do_wr(16'hFF85, 8'h66);
        do_rd(16'hFF85, 8'h66, "R8 hram FF85");
        do_wr(16'hFFFF, 8'h99);
        do_rd(16'hFFFF, 8'h99, "R8 hram FFFF");

        // R9 I/O ports
        do_wr(16'hFF47, 8'h3A);
        do_rd(16'hFF47, 8'h3A, "R9 vreg FF47");
        do_wr(16'hFF65, 8'h4B);
        do_rd(16'hFF65, 8'h4B, "R9 vreg FF65");
        do_rd(16'hFF55, 8'h55 ^ 8'hA5, "R9 vreg read FF55");
        do_wr(16'hFF05, 8'h12);
        check(pad_last_addr == 4'h5, "R9 pad addr", {12'h0, pad_last_addr}, 16'h5);
        check(pad_last_data == 8'h12, "R9 pad data", {8'h0, pad_last_data}, 16'h12);

        // R12 simultaneous strobes act as a read
        @(negedge clk);
        begin
            rd_item_t it;
            cpu_addr = 16'hC123;
            cpu_wdata = 8'h99;
            cpu_rd = 1'b1;
            cpu_wr = 1'b1;
            it.exp = 8'h11;
            it.tag = "R12 collision read";
            sb.push_back(it);
        end
        idle();
        do_rd(16'hC123, 8'h11, "R12 collision no write");

        // R3 release by final boot fetch
        do_rd(16'h00FE, boot_byte(8'hFE), "R3 boot 00FE");
        idle();
        check(boot_overlay == 1'b0, "R3 overlay released", {15'h0, boot_overlay}, 16'h0);
        do_rd(16'h0000, rom_byte(15'h0000), "R3 rom 0000 after release");
        do_rd(16'h00FE, rom_byte(15'h00FE), "R3 rom 00FE after release");
        idle();
        check(boot_overlay == 1'b0, "R3 overlay stays", {15'h0, boot_overlay}, 16'h0);

        // R3 release by write after a fresh reset
        do_reset();
        check(boot_overlay == 1'b1, "R1 overlay after second reset", {15'h0, boot_overlay}, 16'h1);
        do_rd(16'h0010, boot_byte(8'h10), "R2 boot 0010 again");
        do_wr(16'hFF50, 8'h00);
        check(boot_overlay == 1'b0, "R3 FF50 release", {15'h0, boot_overlay}, 16'h0);
        pulse_chk("R3 FF50 no flags", 1'b0, 1'b0, 1'b0);
        do_rd(16'h0010, rom_byte(15'h0010), "R3 rom 0010 after write release");

        repeat (3) idle();
        check(sb.size() == 0, "R12 all reads returned", 16'(sb.size()), 16'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule